// File: doc/BRIEF.md
# Two-Half Frame Slip Buffer

This block is the receive elastic store between a line-side timebase and a system-bus timebase. Both sides run from one clock and move one byte per slot strobe. The line side writes with `wr_en` and the system side reads with `rd_en`. The storage holds two frames of 32 byte-wide slots each, a low half and a high half, for 64 entries in all. A 6-bit write slot counter and a 6-bit read slot counter run across both halves. Bit 5 of each counter is the half that side is using.

When the two timebases drift far enough apart to collide, the reader takes a controlled frame slip and keeps slot alignment. It either replays the previous frame or drops one frame. A small control state machine records which slip happened and emits a one-cycle pulse for it. The machine has three states. ST_TRACK is normal transfer. ST_REPEAT is held for the cycle after a repeat slip, and ST_SKIP for the cycle after a skip slip. Every cycle the machine takes one of three transitions: to ST_REPEAT on a repeat request, to ST_SKIP on a skip request, and otherwise to ST_TRACK. This holds from any state.

A byte-wide status word gives software three things. It holds the write-to-read distance in whole slots, captured once per read frame. It also holds the half each side is working in, so that a processor can reach the idle half.

Top module: `frame_slip_buffer`

## Requirements
- R1: After reset the writer is in the low half and the reader in the high half. The delay code is 32, `status` reads 8'h81, and `rd_vld`, `frm_evt`, `slip_rep` and `slip_skip` are all low.
- R2: Every read strobe gives `rd_vld` high one cycle later, with `rd_data` holding the byte at the effective read slot. Without slips, bytes come out in the order they were written.
- R3: `status[7:2]` is the delay code, `status[1]` is bit 5 of the write slot counter (0 = low half, 1 = high half), and `status[0]` is bit 5 of the read slot counter. The half bits change one cycle after the strobe that moves the counter.
- R4: A read strobe whose effective slot index mod 32 is 0 marks a frame event. The delay code becomes (write counter − effective read slot) mod 64, with the write counter taken before that cycle's write. `frm_evt` pulses high in the following cycle. At all other times the code holds.
- R5: A read strobe with the write counter equal to the read counter is a repeat slip. The read uses the same slot in the other half, the read counter continues from there, and `slip_rep` pulses one cycle later.
- R6: A write strobe without a read strobe, when the write counter plus 1 (mod 64) equals the read counter, is a skip slip. The write still happens, the read counter flips its half bit, and `slip_skip` pulses one cycle later.
- R7: `slip_rep` and `slip_skip` are never high together.
- R8: In a cycle with neither strobe, both counters, and so `status[1:0]`, keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both timebases |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Line-side slot strobe, writes one byte |
| wr_data | input | 8 | Byte from the line side |
| rd_en | input | 1 | System-side slot strobe, reads one byte |
| rd_data | output | 8 | Byte delivered to the system side |
| rd_vld | output | 1 | `rd_data` valid, one cycle after `rd_en` |
| frm_evt | output | 1 | Frame event pulse, delay code just updated |
| slip_rep | output | 1 | Repeat slip pulse |
| slip_skip | output | 1 | Skip slip pulse |
| status | output | 8 | {delay code, writer half, reader half} |

## Verification
All results come out after exactly one register stage. Read data with `rd_vld`, `frm_evt`, the slip pulses, the new delay code and the half bits are all due on the first rising edge after the strobe cycle. The bench drives strobes just after a falling edge and samples one falling edge later, so every comparison lands in the middle of the cycle in which the result is valid. A reference model in the bench predicts each byte, pulse and status value. It pushes expected bytes into a queue, and a monitor pops and compares them whenever `rd_vld` is high. Three rate patterns are run: equal rates, a faster writer that forces skips, and a faster reader that forces repeats.

// File: rtl/slip_buf_pkg.sv
package slip_buf_pkg;
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_REPEAT = 2'd1,
        ST_SKIP   = 2'd2
    } slip_state_e;
endpackage

// File: rtl/slip_ptr.sv
module slip_ptr #(
    parameter int AW      = 6,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          flip,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] HALF_MASK = AW'(1) << (AW - 1);

    logic [AW-1:0] ptr_n;

    always_comb begin
        ptr_n = (flip ? (ptr ^ HALF_MASK) : ptr) + AW'(step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= AW'(RST_VAL);
        else        ptr <= ptr_n;
    end

    // R8: an idle side never moves its counter
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !flip) |=> $stable(ptr));
endmodule

// File: rtl/slip_mem.sv
module slip_mem #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvld
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            rvld  <= 1'b0;
        end else begin
            rvld <= re;
            if (re) rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl
    import slip_buf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] wptr,
    input  logic [AW-1:0] rptr,
    output logic          rep_req,
    output logic          skip_req,
    output logic          slip_rep,
    output logic          slip_skip
);
    slip_state_e state, state_n;

    always_comb begin
        rep_req  = rd_en && (wptr == rptr);
        skip_req = wr_en && !rd_en && (AW'(wptr + AW'(1)) == rptr);
    end

    always_comb begin
        if (rep_req)       state_n = ST_REPEAT;
        else if (skip_req) state_n = ST_SKIP;
        else               state_n = ST_TRACK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_TRACK;
        else        state <= state_n;
    end

    always_comb begin
        slip_rep  = 1'b0;
        slip_skip = 1'b0;
        unique case (state)
            ST_TRACK:  ;
            ST_REPEAT: slip_rep  = 1'b1;
            ST_SKIP:   slip_skip = 1'b1;
            default:   ;
        endcase
    end

    // R7: the two slip kinds are exclusive
    p_slip_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(slip_rep && slip_skip));
    // R5: a read into the slot being written yields a repeat pulse
    p_rep_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wptr == rptr) |=> slip_rep);
    // R6: a lone write catching the reader yields a skip pulse
    p_skip_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && AW'(wptr + AW'(1)) == rptr) |=> slip_skip);
endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer #(
    parameter int SLOT_BITS   = 8,
    parameter int FRAME_SLOTS = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SLOT_BITS-1:0]              wr_data,
    input  logic                              rd_en,
    output logic [SLOT_BITS-1:0]              rd_data,
    output logic                              rd_vld,
    output logic                              frm_evt,
    output logic                              slip_rep,
    output logic                              slip_skip,
    output logic [$clog2(FRAME_SLOTS)+2:0]    status
);
    localparam int HAW = $clog2(FRAME_SLOTS);
    localparam int AW  = HAW + 1;
    localparam logic [AW-1:0] HALF_MASK = AW'(1) << HAW;

    logic [AW-1:0] wptr, rptr, rd_addr, delay_q;
    logic          rep_req, skip_req, frame_start;

    slip_ptr #(.AW(AW), .RST_VAL(0)) u_wptr (
        .clk(clk), .rst_n(rst_n), .step(wr_en), .flip(1'b0), .ptr(wptr)
    );

    slip_ptr #(.AW(AW), .RST_VAL(FRAME_SLOTS)) u_rptr (
        .clk(clk), .rst_n(rst_n), .step(rd_en),
        .flip(rep_req | skip_req), .ptr(rptr)
    );

    slip_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wptr(wptr), .rptr(rptr), .rep_req(rep_req), .skip_req(skip_req),
        .slip_rep(slip_rep), .slip_skip(slip_skip)
    );

    always_comb begin
        rd_addr     = rep_req ? (rptr ^ HALF_MASK) : rptr;
        frame_start = rd_en && (rd_addr[HAW-1:0] == '0);
    end

    slip_mem #(.DW(SLOT_BITS), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wptr), .wdata(wr_data),
        .re(rd_en), .raddr(rd_addr), .rdata(rd_data), .rvld(rd_vld)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delay_q <= AW'(FRAME_SLOTS);
            frm_evt <= 1'b0;
        end else begin
            frm_evt <= frame_start;
            if (frame_start) delay_q <= wptr - rd_addr;
        end
    end

    assign status = {delay_q, wptr[AW-1], rptr[AW-1]};

    // R2: every read strobe is answered in the next cycle
    p_vld_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);
    // R4: frame event pulse follows a frame-start read
    p_frm_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> frm_evt);
    // R4: delay code holds between frame events
    p_delay_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(status[AW+1:2]));
endmodule

// File: tb/sim_frame_slip_buffer.sv
`timescale 1ns/100ps
module sim_frame_slip_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_vld, frm_evt, slip_rep, slip_skip;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] bmem [64];
    int bw = 0, br = 32, bdelay = 32;
    bit e_rep, e_skip, e_frm;
    logic [7:0] exp_q [$];
    logic [7:0] seq = 8'd1;

    always #2.5 clk = ~clk;

    frame_slip_buffer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld), .frm_evt(frm_evt),
        .slip_rep(slip_rep), .slip_skip(slip_skip), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive, predict, then sample after the edge
    task automatic cycle(input bit we, input bit re);
        int reff;
        bit rep, skp;
        wr_en   = we;
        rd_en   = re;
        wr_data = seq;
        rep  = re && (bw == br);
        skp  = we && !re && (((bw + 1) % 64) == br);
        reff = rep ? (br ^ 32) : br;
        e_frm = 1'b0;
        if (re) begin
            exp_q.push_back(bmem[reff]);
            if ((reff % 32) == 0) begin
                e_frm  = 1'b1;
                bdelay = (bw - reff + 64) % 64;
            end
        end
        if (we) begin
            bmem[bw] = seq;
            bw = (bw + 1) % 64;
            seq++;
        end
        if (re)  br = (reff + 1) % 64;
        if (skp) br = br ^ 32;
        e_rep  = rep;
        e_skip = skp;
        @(negedge clk);
        chk(slip_rep == e_rep, "R5 slip_rep", slip_rep, e_rep);
        chk(slip_skip == e_skip, "R6 slip_skip", slip_skip, e_skip);
        chk(!(slip_rep && slip_skip), "R7 exclusive", {slip_rep, slip_skip}, 0);
        chk(frm_evt == e_frm, "R4 frm_evt", frm_evt, e_frm);
        chk(status[7:2] == 6'(bdelay), "R4 delay code", status[7:2], bdelay);
        chk(status[1:0] == {bw[5], br[5]}, "R3 half bits", status[1:0], {bw[5], br[5]});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected rd_vld", rd_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R2 read data", rd_data, e);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nrep, nskip;
        for (int i = 0; i < 64; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'h81, "R1 status", status, 8'h81);
        chk(!rd_vld && !frm_evt && !slip_rep && !slip_skip, "R1 pulses",
            {rd_vld, frm_evt, slip_rep, slip_skip}, 0);

        // R8 idle cycles keep everything
        repeat (4) cycle(1'b0, 1'b0);
        chk(status == 8'h81, "R8 idle hold", status, 8'h81);

        // equal rates: delay stays one frame
        for (int i = 0; i < 200; i++) cycle(1'b1, 1'b1);
        chk(status[7:2] == 6'd32, "R4 nominal delay", status[7:2], 32);

        // faster writer: skips must occur
        nskip = 0;
        for (int i = 0; i < 600; i++) begin
            cycle(1'b1, (i % 4) != 0);
            if (slip_skip) nskip++;
        end
        chk(nskip > 0, "R6 skip occurred", nskip, 1);

        // R8 idle mid-run
        begin
            logic [1:0] h;
            h = status[1:0];
            repeat (3) cycle(1'b0, 1'b0);
            chk(status[1:0] == h, "R8 idle halves", status[1:0], h);
        end

        // faster reader: repeats must occur
        nrep = 0;
        for (int i = 0; i < 600; i++) begin
            cycle((i % 4) != 0, 1'b1);
            if (slip_rep) nrep++;
        end
        chk(nrep > 0, "R5 repeat occurred", nrep, 1);

        // mixed sparse pattern
        for (int i = 0; i < 300; i++) cycle((i % 3) != 1, (i % 5) != 2);

        cycle(1'b0, 1'b0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule